// File: doc/BRIEF.md
# Odd/Even/Full Inversion Codec

This block lowers the number of ones carried on an 8-bit data path by re-coding each word into a 10-bit code word. The encoder counts the ones in the word and picks one of four transforms. A word that is mostly ones is complemented. A word that is mostly zeros is sent as it is. A word with exactly as many ones as zeros has only its odd-indexed or only its even-indexed bits complemented. The two-bit mode it picked is sent in front of the transformed data. A matching combinational decoder reads the mode and reverses the transform.

The encoder is a one-stage pipeline with a valid/ready stream on each side. A word is taken when `enc_in_valid` and `enc_in_ready` are both high at a rising edge. Its code word is presented on the next cycle with `enc_out_valid` high. The code word stays there, unchanged, until a rising edge finds `enc_out_ready` high. While the held code word is blocked, `enc_in_ready` is low, so back-pressure reaches the producer in the same cycle. When the stage is empty, or is being drained in the same cycle, `enc_in_ready` is high. The decoder has no state and no handshake: it maps `dec_code` to `dec_data` within the same cycle.

Top module: `bic_codec`

## Requirements
- R1: A code word is `{mode[1:0], data[7:0]}`. The mode occupies bits 9:8 and the transformed data occupies bits 7:0.
- R2: When the input word holds more than four ones, the mode is 2'b00 and the data field is the bitwise complement of the input. For example, 8'hFF encodes to 10'h000.
- R3: When the input word holds fewer than four ones, the mode is 2'b11 and the data field equals the input.
- R4: When the input word holds exactly four ones, and more of them sit at odd indices (1, 3, 5, 7) than at even indices, the mode is 2'b10 and the data field is the input XOR 8'hAA.
- R5: When the input word holds exactly four ones, and the even indices (0, 2, 4, 6) hold at least as many of them as the odd indices, the mode is 2'b01 and the data field is the input XOR 8'h55.
- R6: For every mode, the decoder returns the 8-bit data field XOR the mask of that mode: 8'hFF for 00, 8'h55 for 01, 8'hAA for 10 and 8'h00 for 11. Decoding an encoder output therefore returns the original word.
- R7: The data field of a code word never holds more ones than the input word it came from.
- R8: A word accepted at one rising edge appears on `enc_out_code` with `enc_out_valid` high after that edge, which is one cycle of latency.
- R9: While `enc_out_valid` is high and `enc_out_ready` is low, `enc_out_code` and `enc_out_valid` hold their values and `enc_in_ready` is low. Otherwise `enc_in_ready` is high.
- R10: A rising edge with `rst` high clears `enc_out_valid` and `enc_out_code` to zero. No valid output appears while `rst` is held, even if `enc_in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enc_in_valid | input | 1 | Input word is valid |
| enc_in_ready | output | 1 | Encoder can accept a word this cycle |
| enc_in_data | input | 8 | Word to encode |
| enc_out_valid | output | 1 | Code word is valid |
| enc_out_ready | input | 1 | Consumer accepts the code word this cycle |
| enc_out_code | output | 10 | Code word: mode in bits 9:8, data in bits 7:0 |
| dec_code | input | 10 | Code word to decode |
| dec_data | output | 8 | Decoded word |

## Verification
The bench builds the block with its default width of 8. At that width every one of the 256 input words can be streamed through the encoder. Each word is decoded back, and its weight is compared with the weight of the input. The decoder is also driven with all 1024 possible code words, including ones the encoder never produces. Random valid and ready patterns then stall the output stage in many different cycles, and a reset is asserted while a word is held.

// File: rtl/bic_pkg.sv
package bic_pkg;
  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_EVEN = 2'b01,
    MODE_ODD  = 2'b10,
    MODE_PASS = 2'b11
  } inv_mode_e;
endpackage

// File: rtl/bic_parity_counter.sv
module bic_parity_counter #(
  parameter int W  = 8,
  parameter int CW = $clog2(W/2 + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] odd_cnt,
  output logic [CW-1:0] even_cnt
);
  localparam int HALF = W / 2;

  logic [HALF-1:0] odd_bits;
  logic [HALF-1:0] even_bits;

  for (genvar k = 0; k < HALF; k++) begin : g_split
    assign even_bits[k] = din[2*k];
    assign odd_bits[k]  = din[2*k+1];
  end

  always_comb begin
    odd_cnt  = '0;
    even_cnt = '0;
    for (int k = 0; k < HALF; k++) begin
      odd_cnt  = odd_cnt  + CW'(odd_bits[k]);
      even_cnt = even_cnt + CW'(even_bits[k]);
    end
  end
endmodule

// File: rtl/bic_mode_pick.sv
module bic_mode_pick
  import bic_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = $clog2(W/2 + 1)
) (
  input  logic [CW-1:0] odd_cnt,
  input  logic [CW-1:0] even_cnt,
  output inv_mode_e     mode
);
  localparam logic [CW:0] BAL = (CW+1)'(W/2);

  logic [CW:0] total;
  assign total = {1'b0, odd_cnt} + {1'b0, even_cnt};

  always_comb begin
    if (total > BAL)             mode = MODE_FULL;
    else if (total < BAL)        mode = MODE_PASS;
    else if (odd_cnt > even_cnt) mode = MODE_ODD;
    else                         mode = MODE_EVEN;
  end
endmodule

// File: rtl/bic_mask_gen.sv
module bic_mask_gen
  import bic_pkg::*;
#(
  parameter int W = 8
) (
  input  inv_mode_e    mode,
  output logic [W-1:0] mask
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i % 2 == 1) begin : g_odd
      assign mask[i] = (mode == MODE_FULL) || (mode == MODE_ODD);
    end else begin : g_even
      assign mask[i] = (mode == MODE_FULL) || (mode == MODE_EVEN);
    end
  end
endmodule

// File: rtl/bic_encoder.sv
module bic_encoder
  import bic_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W+1:0] out_code
);
  localparam int CW = $clog2(W/2 + 1);

  logic [CW-1:0] odd_cnt, even_cnt;
  inv_mode_e     mode;
  logic [W-1:0]  mask;
  logic          accept;

  bic_parity_counter #(.W(W), .CW(CW)) u_count (
    .din(in_data), .odd_cnt(odd_cnt), .even_cnt(even_cnt)
  );

  bic_mode_pick #(.W(W), .CW(CW)) u_pick (
    .odd_cnt(odd_cnt), .even_cnt(even_cnt), .mode(mode)
  );

  bic_mask_gen #(.W(W)) u_mask (.mode(mode), .mask(mask));

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_code  <= {mode, in_data ^ mask};
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: accepted word shows up on the next cycle
  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R9: a stalled code word holds still
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

  // R10: reset empties the stage
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && out_code == '0));

  // R7: the data field never gains weight
  p_weight_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> ($countones(out_code[W-1:0]) <= $countones($past(in_data))));

  // R2: heavy words are sent fully inverted
  p_heavy_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && $countones(in_data) > W/2) |=> (out_code[W+1:W] == MODE_FULL));

  // R3: light words pass unchanged
  p_light_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && $countones(in_data) < W/2) |=>
      (out_code == {MODE_PASS, $past(in_data)}));

  // R4 and R5: balanced words use a partial mode
  p_balanced_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && $countones(in_data) == W/2) |=>
      (out_code[W+1:W] == MODE_ODD || out_code[W+1:W] == MODE_EVEN));
endmodule

// File: rtl/bic_decoder.sv
module bic_decoder
  import bic_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W+1:0] code,
  output logic [W-1:0] data
);
  inv_mode_e    mode;
  logic [W-1:0] mask;

  assign mode = inv_mode_e'(code[W+1:W]);

  bic_mask_gen #(.W(W)) u_mask (.mode(mode), .mask(mask));

  assign data = code[W-1:0] ^ mask;

  // R6: number of flipped bits matches the mode
  always_comb begin
    if (!$isunknown(code)) begin
      p_flip_count_r6: assert ($countones(data ^ code[W-1:0]) ==
        ((mode == MODE_FULL) ? W : (mode == MODE_PASS) ? 0 : W/2))
        else $error("decoder flipped an unexpected number of bits");
    end
  end
endmodule

// File: rtl/bic_codec.sv
module bic_codec #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enc_in_valid,
  output logic         enc_in_ready,
  input  logic [W-1:0] enc_in_data,
  output logic         enc_out_valid,
  input  logic         enc_out_ready,
  output logic [W+1:0] enc_out_code,
  input  logic [W+1:0] dec_code,
  output logic [W-1:0] dec_data
);
  bic_encoder #(.W(W)) u_enc (
    .clk(clk), .rst(rst),
    .in_valid(enc_in_valid), .in_ready(enc_in_ready), .in_data(enc_in_data),
    .out_valid(enc_out_valid), .out_ready(enc_out_ready), .out_code(enc_out_code)
  );

  bic_decoder #(.W(W)) u_dec (.code(dec_code), .data(dec_data));
endmodule

// File: tb/bic_codec_tb.sv
`timescale 1ns/1ps
module bic_codec_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [9:0] out_code;
  logic [9:0] dec_code = 10'h000;
  logic [7:0] dec_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit       mv = 0;
  bit [9:0] mcode = 10'h000;
  bit [7:0] mdata = 8'h00;

  always #5 clk = ~clk;

  bic_codec u_dut (
    .clk(clk), .rst(rst),
    .enc_in_valid(in_valid), .enc_in_ready(in_ready), .enc_in_data(in_data),
    .enc_out_valid(out_valid), .enc_out_ready(out_ready), .enc_out_code(out_code),
    .dec_code(dec_code), .dec_data(dec_data)
  );

  function automatic bit [9:0] ref_enc(input bit [7:0] d);
    int ones = 0, oddc = 0, evenc = 0;
    for (int i = 0; i < 8; i++) begin
      if (d[i]) begin
        ones++;
        if (i % 2 == 1) oddc++; else evenc++;
      end
    end
    if (ones > 4)          return {2'b00, ~d};
    else if (ones < 4)     return {2'b11, d};
    else if (oddc > evenc) return {2'b10, d ^ 8'hAA};
    else                   return {2'b01, d ^ 8'h55};
  endfunction

  function automatic string tag_of(input bit [9:0] c);
    case (c[9:8])
      2'b00:   return "R2";
      2'b11:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input bit v, input bit [7:0] d, input bit ordy, input bit r);
    bit rdy;
    @(negedge clk);
    chk(out_valid === mv, "R8 valid", 32'(out_valid), 32'(mv));
    chk(out_code === mcode, mv ? tag_of(mcode) : "R10 code", 32'(out_code), 32'(mcode));
    chk(in_ready === (!mv || out_ready), "R9 ready", 32'(in_ready),
        32'(!mv || out_ready));
    if (mv) begin
      dec_code = out_code;
      #1;
      chk(dec_data === mdata, "R6 roundtrip", 32'(dec_data), 32'(mdata));
      chk($countones(out_code[7:0]) <= $countones(mdata), "R7 weight",
          32'($countones(out_code[7:0])), 32'($countones(mdata)));
      chk(out_code[9:8] === mcode[9:8], "R1 mode field", 32'(out_code[9:8]),
          32'(mcode[9:8]));
    end
    in_valid  = v;
    in_data   = d;
    out_ready = ordy;
    rst       = r;
    if (r) begin
      mv = 0;
      mcode = 10'h000;
    end else begin
      rdy = !mv || ordy;
      if (mv && ordy) mv = 0;
      if (v && rdy) begin
        mv = 1;
        mcode = ref_enc(d);
        mdata = d;
      end
    end
  endtask

  initial begin
    // R10: reset held with input offered
    for (int i = 0; i < 3; i++) step(1, 8'hFF, 1, 1);
    // exhaustive stream at full rate
    for (int i = 0; i < 256; i++) step(1, 8'(i), 1, 0);
    step(0, 8'h00, 1, 0);
    // R2: directed all-ones word
    step(1, 8'hFF, 1, 0);
    step(0, 8'h00, 1, 0);
    chk(out_code === 10'h000, "R2 all ones", 32'(out_code), 32'h000);
    // R4 and R5 directed balanced words
    step(1, 8'hAA, 0, 0);
    step(0, 8'h00, 1, 0);
    chk(out_code === 10'h200, "R4 odd heavy", 32'(out_code), 32'h200);
    step(1, 8'h0F, 1, 0);
    step(0, 8'h00, 1, 0);
    chk(out_code === 10'h15A, "R5 tie", 32'(out_code), 32'h15A);
    // R9: random back-pressure
    for (int i = 0; i < 400; i++)
      step(($urandom % 3) != 0, 8'($urandom), ($urandom % 3) != 0, 0);
    // R10: reset while a word is held
    step(1, 8'h3C, 0, 0);
    step(0, 8'h00, 0, 0);
    step(1, 8'h11, 0, 1);
    step(0, 8'h00, 1, 0);
    step(0, 8'h00, 1, 0);
    // R6: every code word through the decoder
    @(negedge clk);
    for (int c = 0; c < 1024; c++) begin
      bit [7:0] m;
      dec_code = 10'(c);
      #1;
      case (c[9:8])
        2'b00:   m = 8'hFF;
        2'b01:   m = 8'h55;
        2'b10:   m = 8'hAA;
        default: m = 8'h00;
      endcase
      chk(dec_data === (8'(c) ^ m), "R6 decode", 32'(dec_data), 32'(8'(c) ^ m));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule